// File: doc/BRIEF.md
# Local Scan Port Park Controller

This block sits behind a master test access port and looks after three local scan ports, each of which leads to a board-level chain of TAP devices. It does not contain a TAP state machine. The master controller's current state comes in as a 4-bit code, and decoded instructions come in as one-cycle command strobes. From these inputs the block decides, for each port, one of three things: hold the local TAP in Test-Logic-Reset, hold it in Run-Test/Idle, or pass the master TMS straight through to it.

A mode register selects which local chains are spliced into the serial path between the block's TDI and its scan output. A port is in the path only when it is enabled in the register and it is following the master. Enabled chains are placed in series in ascending port order. Parking a port lets the local devices keep a loaded instruction, for example an external test pattern that keeps driving, while the master works on something else.

An unpark request only takes effect when the master TAP reaches the same stable state that the parked port is holding. This keeps the master and local state machines in step.

Top module: `lsp_park_ctrl`

## Requirements
- R1: While trst_n is low, every lsp_tms output is 1 at once, without waiting for a clock edge. After release, the mode register reads 0 and no port is in the scan path.
- R2: A cmd_modesel strobe connects the 8-bit mode register to the scan path. With it connected, master state Capture-DR (4'h6) loads the register value into a shift stage. Shift-DR (4'h2) shifts it LSB first, taking tdi in at the top and presenting bit 0 on scan_out. Update-DR (4'h5) writes the shift stage back into the register. Any other command strobe disconnects the register. Bits 7..3 have no function but read back as written.
- R3: Mode bit 0 enables port 1 (index 0), bit 1 enables port 2 and bit 2 enables port 3. The ports that are in the path are chained in ascending order: tdi goes to lsp_tdi[0], lsp_tdo[0] goes to lsp_tdi[1], and so on. The last port in the path drives scan_out. The value 8'h07 chains all three ports, and 8'h02 inserts port 2 alone.
- R4: cmd_parktlr parks every port in Test-Logic-Reset. From the next cycle, every lsp_tms is 1 and any pending unpark is cancelled.
- R5: cmd_parkrti parks every port in Run-Test/Idle. From the next cycle, every lsp_tms is 0, whatever the master TMS does.
- R6: cmd_unpark marks each parked port that is enabled in the mode register as pending. A pending port parked in Run-Test/Idle joins in the first cycle in which the master state is 4'hC. A pending port parked in Test-Logic-Reset joins in the first cycle in which the master state is 4'hF. From that cycle onward, its lsp_tms equals the master tms.
- R7: cmd_softreset drives every lsp_tms to 1 from the next cycle, cancels any pending unpark and leaves the mode register unchanged.
- R8: A port that is parked, or not enabled, is bypassed. Its lsp_tdo has no effect on scan_out or on any later lsp_tdi.
- R9: A master state of Test-Logic-Reset (4'hF) clears the mode register to 0 and disconnects it from the scan path. It also parks every following port that is not pending in Test-Logic-Reset, and while the master is in that state such a port's lsp_tms is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tap_state | input | 4 | Current master TAP state code |
| tms | input | 1 | Master TMS |
| tdi | input | 1 | Serial data into the block |
| cmd_unpark | input | 1 | Strobe: unpark enabled ports |
| cmd_parktlr | input | 1 | Strobe: park all ports in Test-Logic-Reset |
| cmd_parkrti | input | 1 | Strobe: park all ports in Run-Test/Idle |
| cmd_softreset | input | 1 | Strobe: force all local TAPs to reset |
| cmd_modesel | input | 1 | Strobe: connect the mode register to the scan path |
| lsp_tdo | input | 3 | Serial data returned by each local chain |
| lsp_tms | output | 3 | Local TMS per port |
| lsp_tdi | output | 3 | Serial data sent to each local chain |
| scan_out | output | 1 | Serial data leaving the block |

## Verification
A port whose parked state is wrong shows up on its lsp_tms within one cycle: a 1 where a 0 is expected, or a value that does not follow the master. Each park, unpark and reset step is therefore checked in the cycle right after its strobe or its synchronising master state. A join that happens too early or too late shows up as lsp_tms following tms in the wrong cycle. A wrong mode register or a wrong path-membership bit shows up combinationally on lsp_tdi and scan_out when distinct lsp_tdo patterns are applied. The register contents themselves become visible on scan_out during the next eight-cycle readback.

// File: rtl/lsp_pkg.sv
package lsp_pkg;

    typedef enum logic [3:0] {
        TAP_EX2_DR   = 4'h0,
        TAP_EX1_DR   = 4'h1,
        TAP_SHIFT_DR = 4'h2,
        TAP_PAUSE_DR = 4'h3,
        TAP_SEL_IR   = 4'h4,
        TAP_UPD_DR   = 4'h5,
        TAP_CAP_DR   = 4'h6,
        TAP_SEL_DR   = 4'h7,
        TAP_EX2_IR   = 4'h8,
        TAP_EX1_IR   = 4'h9,
        TAP_SHIFT_IR = 4'hA,
        TAP_PAUSE_IR = 4'hB,
        TAP_IDLE     = 4'hC,
        TAP_UPD_IR   = 4'hD,
        TAP_CAP_IR   = 4'hE,
        TAP_RESET    = 4'hF
    } tap_st_e;

    typedef enum logic [1:0] {
        LP_PARK_TLR = 2'd0,
        LP_PARK_RTI = 2'd1,
        LP_ACTIVE   = 2'd2
    } lp_st_e;

    typedef struct packed {
        lp_st_e st;
        logic   pend;
    } lp_reg_t;

endpackage

// File: rtl/lsp_mode_reg.sv
module lsp_mode_reg
    import lsp_pkg::*;
#(
    parameter int MODE_W = 8,
    parameter int NP     = 3
) (
    input  logic          tck,
    input  logic          trst_n,
    input  logic [3:0]    tap_state,
    input  logic          tdi,
    input  logic          cmd_modesel,
    input  logic          cmd_other,
    output logic [NP-1:0] mode_en,
    output logic          sel_q,
    output logic          sr_out
);

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [MODE_W-1:0] sr;
        logic              sel;
    } mr_t;

    mr_t     r_q, r_d;
    tap_st_e st;

    assign st = tap_st_e'(tap_state);

    always_comb begin
        r_d = r_q;
        if (st == TAP_RESET) begin
            r_d.mode = '0;
            r_d.sel  = 1'b0;
        end else begin
            if (cmd_modesel)    r_d.sel = 1'b1;
            else if (cmd_other) r_d.sel = 1'b0;
            if (r_q.sel) begin
                case (st)
                    TAP_CAP_DR:   r_d.sr   = r_q.mode;
                    TAP_SHIFT_DR: r_d.sr   = {tdi, r_q.sr[MODE_W-1:1]};
                    TAP_UPD_DR:   r_d.mode = r_q.sr;
                    default:      ;
                endcase
            end
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) r_q <= '0;
        else         r_q <= r_d;
    end

    assign mode_en = r_q.mode[NP-1:0];
    assign sel_q   = r_q.sel;
    assign sr_out  = r_q.sr[0];

endmodule

// File: rtl/lsp_port_fsm.sv
module lsp_port_fsm
    import lsp_pkg::*;
(
    input  logic tck,
    input  logic trst_n,
    input  logic master_tlr,
    input  logic master_rti,
    input  logic tms,
    input  logic enable,
    input  logic cmd_unpark,
    input  logic cmd_parktlr,
    input  logic cmd_parkrti,
    input  logic cmd_softreset,
    output logic tms_out,
    output logic active
);

    lp_reg_t p_q, p_d;
    logic    join_now;

    always_comb begin
        join_now = p_q.pend &&
                   ((p_q.st == LP_PARK_TLR && master_tlr) ||
                    (p_q.st == LP_PARK_RTI && master_rti));
        p_d = p_q;
        if (cmd_softreset || cmd_parktlr) begin
            p_d.st   = LP_PARK_TLR;
            p_d.pend = 1'b0;
        end else if (cmd_parkrti) begin
            p_d.st   = LP_PARK_RTI;
            p_d.pend = 1'b0;
        end else if (cmd_unpark) begin
            if (p_q.st != LP_ACTIVE && enable) p_d.pend = 1'b1;
        end else if (join_now) begin
            p_d.st   = LP_ACTIVE;
            p_d.pend = 1'b0;
        end else if (master_tlr) begin
            p_d.st   = LP_PARK_TLR;
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) p_q <= '{st: LP_PARK_TLR, pend: 1'b0};
        else         p_q <= p_d;
    end

    // The joining cycle already passes the master TMS so both TAPs move together.
    always_comb begin
        if (join_now)
            tms_out = tms;
        else if (p_q.st == LP_ACTIVE && !master_tlr)
            tms_out = tms;
        else if (p_q.st == LP_PARK_RTI)
            tms_out = 1'b0;
        else
            tms_out = 1'b1;
    end

    assign active = (p_q.st == LP_ACTIVE);

endmodule

// File: rtl/lsp_park_ctrl.sv
module lsp_park_ctrl
    import lsp_pkg::*;
#(
    parameter int NUM_PORTS = 3,
    parameter int MODE_W    = 8
) (
    input  logic                 tck,
    input  logic                 trst_n,
    input  logic [3:0]           tap_state,
    input  logic                 tms,
    input  logic                 tdi,
    input  logic                 cmd_unpark,
    input  logic                 cmd_parktlr,
    input  logic                 cmd_parkrti,
    input  logic                 cmd_softreset,
    input  logic                 cmd_modesel,
    input  logic [NUM_PORTS-1:0] lsp_tdo,
    output logic [NUM_PORTS-1:0] lsp_tms,
    output logic [NUM_PORTS-1:0] lsp_tdi,
    output logic                 scan_out
);

    localparam int CHAIN_N = NUM_PORTS + 1;

    logic [NUM_PORTS-1:0] port_active;
    logic [NUM_PORTS-1:0] mode_en;
    logic                 mode_sel;
    logic                 mode_sr_out;
    logic [CHAIN_N-1:0]   chain;
    logic                 master_tlr, master_rti, cmd_other;

    assign master_tlr = (tap_st_e'(tap_state) == TAP_RESET);
    assign master_rti = (tap_st_e'(tap_state) == TAP_IDLE);
    assign cmd_other  = cmd_unpark | cmd_parktlr | cmd_parkrti | cmd_softreset;

    lsp_mode_reg #(.MODE_W(MODE_W), .NP(NUM_PORTS)) u_mode (
        .tck         (tck),
        .trst_n      (trst_n),
        .tap_state   (tap_state),
        .tdi         (tdi),
        .cmd_modesel (cmd_modesel),
        .cmd_other   (cmd_other),
        .mode_en     (mode_en),
        .sel_q       (mode_sel),
        .sr_out      (mode_sr_out)
    );

    assign chain[0] = tdi;

    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
        lsp_port_fsm u_fsm (
            .tck           (tck),
            .trst_n        (trst_n),
            .master_tlr    (master_tlr),
            .master_rti    (master_rti),
            .tms           (tms),
            .enable        (mode_en[i]),
            .cmd_unpark    (cmd_unpark),
            .cmd_parktlr   (cmd_parktlr),
            .cmd_parkrti   (cmd_parkrti),
            .cmd_softreset (cmd_softreset),
            .tms_out       (lsp_tms[i]),
            .active        (port_active[i])
        );
        assign lsp_tdi[i]  = chain[i];
        assign chain[i+1]  = (port_active[i] && mode_en[i]) ? lsp_tdo[i] : chain[i];
    end

    assign scan_out = mode_sel ? mode_sr_out : chain[NUM_PORTS];

endmodule

// File: rtl/lsp_park_chk.sv
module lsp_park_chk #(
    parameter int NP = 3
) (
    input logic          tck,
    input logic          trst_n,
    input logic [3:0]    tap_state,
    input logic          tdi,
    input logic          cmd_unpark,
    input logic          cmd_parktlr,
    input logic          cmd_parkrti,
    input logic          cmd_softreset,
    input logic          cmd_modesel,
    input logic [NP-1:0] lsp_tms,
    input logic          scan_out,
    input logic [NP-1:0] port_active,
    input logic [NP-1:0] mode_en,
    input logic          mode_sel
);

    assert_trst_parked_R1: assert property (@(posedge tck) disable iff (!trst_n)
        $rose(trst_n) |-> (&lsp_tms));

    assert_parktlr_high_R4: assert property (@(posedge tck) disable iff (!trst_n)
        cmd_parktlr |=> (&lsp_tms));

    assert_softreset_high_R7: assert property (@(posedge tck) disable iff (!trst_n)
        cmd_softreset |=> (&lsp_tms));

    assert_bypass_tdi_R8: assert property (@(posedge tck) disable iff (!trst_n)
        (((port_active & mode_en) == '0) && !mode_sel) |-> (scan_out == tdi));

    assert_tlr_clears_mode_R9: assert property (@(posedge tck) disable iff (!trst_n)
        (tap_state == 4'hF) |=> (mode_en == '0 && !mode_sel));

    assert_single_strobe: assert property (@(posedge tck) disable iff (!trst_n)
        $onehot0({cmd_unpark, cmd_parktlr, cmd_parkrti, cmd_softreset, cmd_modesel}));

    for (genvar i = 0; i < NP; i++) begin : g_sync
        assert_join_in_stable_R6: assert property (@(posedge tck) disable iff (!trst_n)
            $rose(port_active[i]) |-> ($past(tap_state) == 4'hF || $past(tap_state) == 4'hC));
    end

endmodule

bind lsp_park_ctrl lsp_park_chk #(.NP(NUM_PORTS)) u_chk (
    .tck           (tck),
    .trst_n        (trst_n),
    .tap_state     (tap_state),
    .tdi           (tdi),
    .cmd_unpark    (cmd_unpark),
    .cmd_parktlr   (cmd_parktlr),
    .cmd_parkrti   (cmd_parkrti),
    .cmd_softreset (cmd_softreset),
    .cmd_modesel   (cmd_modesel),
    .lsp_tms       (lsp_tms),
    .scan_out      (scan_out),
    .port_active   (port_active),
    .mode_en       (mode_en),
    .mode_sel      (mode_sel)
);

// File: tb/sim_lsp_park_ctrl.sv
module sim_lsp_park_ctrl;

    localparam logic [3:0] S_TLR = 4'hF, S_RTI = 4'hC, S_SELDR = 4'h7, S_CAP = 4'h6,
                           S_SHIFT = 4'h2, S_UPD = 4'h5, S_UIR = 4'hD;
    localparam logic [4:0] C_NONE = 5'b00000, C_UN = 5'b00001, C_PT = 5'b00010,
                           C_PR = 5'b00100, C_SR = 5'b01000, C_MS = 5'b10000;

    logic       tck = 1'b0;
    logic       trst_n = 1'b0;
    logic [3:0] tap_state = S_TLR;
    logic       tms = 1'b0, tdi = 1'b0;
    logic [4:0] cmd = C_NONE;
    logic [2:0] lsp_tdo = 3'b000;
    logic [2:0] lsp_tms, lsp_tdi;
    logic       scan_out;

    typedef struct {
        logic [2:0] tms;
        logic       so;
        bit         so_chk;
        logic [2:0] ltdi;
        bit         ltdi_chk;
        string      tag;
    } item_t;

    item_t q[$];
    int    checks = 0, fails = 0;
    bit    done = 1'b0;

    always #10 tck = ~tck;

    lsp_park_ctrl u0 (
        .tck(tck), .trst_n(trst_n), .tap_state(tap_state), .tms(tms), .tdi(tdi),
        .cmd_unpark(cmd[0]), .cmd_parktlr(cmd[1]), .cmd_parkrti(cmd[2]),
        .cmd_softreset(cmd[3]), .cmd_modesel(cmd[4]), .lsp_tdo(lsp_tdo),
        .lsp_tms(lsp_tms), .lsp_tdi(lsp_tdi), .scan_out(scan_out)
    );

    // Monitor: pops one expectation per falling edge
    always @(negedge tck) begin
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            checks++;
            if (lsp_tms !== it.tms || (it.so_chk && scan_out !== it.so) ||
                (it.ltdi_chk && lsp_tdi !== it.ltdi)) begin
                fails++;
                $display("FAIL %s: tms=%b exp %b, scan_out=%b exp %b, lsp_tdi=%b exp %b",
                         it.tag, lsp_tms, it.tms, scan_out, it.so, lsp_tdi, it.ltdi);
            end
        end
    end

    task automatic apply_r(input logic rst, input logic [3:0] st, input logic mt,
                           input logic ti, input logic [2:0] to, input logic [4:0] c,
                           input logic [2:0] etms, input logic eso, input bit cso,
                           input logic [2:0] eltdi, input bit cl, input string tag);
        item_t it;
        @(posedge tck);
        #2;
        trst_n = rst; tap_state = st; tms = mt; tdi = ti; lsp_tdo = to; cmd = c;
        it.tms = etms; it.so = eso; it.so_chk = cso;
        it.ltdi = eltdi; it.ltdi_chk = cl; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic step(input logic [3:0] st, input logic mt, input logic ti,
                        input logic [2:0] to, input logic [4:0] c, input logic [2:0] etms,
                        input logic eso, input bit cso, input logic [2:0] eltdi,
                        input bit cl, input string tag);
        apply_r(1'b1, st, mt, ti, to, c, etms, eso, cso, eltdi, cl, tag);
    endtask

    // Full mode register access: writes wr, expects rd shifted out LSB first
    task automatic mode_scan(input logic [7:0] wr, input logic [7:0] rd,
                             input logic [2:0] etms, input string tag);
        step(S_UIR, 0, 0, 3'b000, C_MS, etms, 0, 0, 3'b000, 0, tag);
        step(S_CAP, 0, 0, 3'b000, C_NONE, etms, 0, 0, 3'b000, 0, tag);
        for (int j = 0; j < 8; j++)
            step(S_SHIFT, 0, wr[j], 3'b000, C_NONE, etms, rd[j], 1, 3'b000, 0, tag);
        step(S_UPD, 0, 0, 3'b000, C_NONE, etms, 0, 0, 3'b000, 0, tag);
        step(S_RTI, 0, 0, 3'b000, C_NONE, etms, 0, 0, 3'b000, 0, tag);
    endtask

    initial begin
        repeat (3) @(posedge tck);
        // R1 / R8: reset state, all chains bypassed
        apply_r(1'b1, S_TLR, 1, 1, 3'b000, C_NONE, 3'b111, 1, 1, 3'b111, 1, "R1");
        step(S_TLR, 0, 0, 3'b111, C_NONE, 3'b111, 0, 1, 3'b000, 1, "R8");
        // R2: write 0xA7, then read back including reserved bits
        mode_scan(8'hA7, 8'h00, 3'b111, "R2");
        mode_scan(8'hA7, 8'hA7, 3'b111, "R2");
        // R6: TLR-parked ports wait for master reset state
        step(S_UIR, 0, 0, 3'b000, C_UN, 3'b111, 0, 0, 3'b000, 0, "R6");
        step(S_RTI, 0, 0, 3'b000, C_NONE, 3'b111, 0, 0, 3'b000, 0, "R6");
        step(S_TLR, 0, 0, 3'b000, C_NONE, 3'b000, 0, 0, 3'b000, 0, "R6");
        step(S_RTI, 1, 0, 3'b111, C_NONE, 3'b111, 0, 1, 3'b000, 0, "R9");
        step(S_SELDR, 0, 0, 3'b000, C_NONE, 3'b000, 0, 0, 3'b000, 0, "R6");
        // R5: park in Run-Test/Idle
        step(S_UIR, 1, 0, 3'b000, C_PR, 3'b111, 0, 0, 3'b000, 0, "R5");
        step(S_RTI, 1, 0, 3'b000, C_NONE, 3'b000, 0, 0, 3'b000, 0, "R5");
        // R9: master reset cleared the register
        mode_scan(8'h07, 8'h00, 3'b000, "R9");
        // R6: RTI-parked ports join in Run-Test/Idle
        step(S_UIR, 1, 0, 3'b000, C_UN, 3'b000, 0, 0, 3'b000, 0, "R6");
        step(S_SELDR, 1, 0, 3'b000, C_NONE, 3'b000, 0, 0, 3'b000, 0, "R6");
        step(S_RTI, 1, 0, 3'b000, C_NONE, 3'b111, 0, 0, 3'b000, 0, "R6");
        // R3: all three in series
        step(S_SHIFT, 0, 1, 3'b010, C_NONE, 3'b000, 0, 1, 3'b101, 1, "R3");
        step(S_SHIFT, 0, 0, 3'b101, C_NONE, 3'b000, 1, 1, 3'b010, 1, "R3");
        // R9: master reset parks following ports
        step(S_TLR, 1, 0, 3'b111, C_NONE, 3'b111, 0, 0, 3'b000, 0, "R9");
        step(S_RTI, 0, 1, 3'b000, C_NONE, 3'b111, 1, 1, 3'b111, 1, "R9");
        // R4
        step(S_UIR, 0, 0, 3'b000, C_PT, 3'b111, 0, 0, 3'b000, 0, "R4");
        step(S_RTI, 0, 1, 3'b000, C_NONE, 3'b111, 1, 1, 3'b111, 1, "R4");
        // R5 from TLR-parked ports
        step(S_UIR, 1, 0, 3'b000, C_PR, 3'b111, 0, 0, 3'b000, 0, "R5");
        step(S_RTI, 1, 0, 3'b000, C_NONE, 3'b000, 0, 0, 3'b000, 0, "R5");
        // R3: port 2 alone
        mode_scan(8'h02, 8'h00, 3'b000, "R2");
        step(S_UIR, 0, 0, 3'b000, C_UN, 3'b000, 0, 0, 3'b000, 0, "R6");
        step(S_RTI, 1, 0, 3'b000, C_NONE, 3'b010, 0, 0, 3'b000, 0, "R6");
        step(S_SHIFT, 0, 0, 3'b111, C_NONE, 3'b000, 1, 1, 3'b100, 1, "R3");
        step(S_SHIFT, 1, 1, 3'b101, C_NONE, 3'b010, 0, 1, 3'b011, 1, "R8");
        // R7
        step(S_UIR, 0, 0, 3'b000, C_SR, 3'b000, 0, 0, 3'b000, 0, "R7");
        step(S_RTI, 0, 0, 3'b000, C_NONE, 3'b111, 0, 0, 3'b000, 0, "R7");
        mode_scan(8'h02, 8'h02, 3'b111, "R7");
        // R1: asynchronous reset mid-run
        step(S_UIR, 0, 0, 3'b000, C_PR, 3'b111, 0, 0, 3'b000, 0, "R5");
        step(S_RTI, 0, 0, 3'b000, C_NONE, 3'b000, 0, 0, 3'b000, 0, "R5");
        apply_r(1'b0, S_RTI, 0, 0, 3'b000, C_NONE, 3'b111, 0, 0, 3'b000, 0, "R1");
        step(S_TLR, 0, 1, 3'b000, C_NONE, 3'b111, 1, 1, 3'b111, 1, "R1");
        mode_scan(8'h00, 8'h00, 3'b111, "R1");
        @(posedge tck);
        @(posedge tck);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run=hung exp=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule